// File: doc/BRIEF.md
# Timer Counter With Source Control

This block is a small microcontroller peripheral. It has an 8-bit up-counter and one control register, and both sit behind a simple register bus. Software uses the control register to start or stop the counter. It also picks what the counter counts: either the core's instruction-cycle tick, or transitions on an external count pin. When the external pin is the source, software chooses whether a rising or a falling transition counts. The external pin is resynchronised before its edges are detected, so each qualifying transition adds exactly one to the count.

The same register holds a 2-bit analog mode field. This field sets how three pins, which the comparator and op-amp share with general-purpose I/O, are used. The block decodes the field into pin-function enables. The register also returns the comparator's result through a read-only bit, which is synchronised before software sees it. Software can load the counter directly through the bus. When the counter wraps from its maximum value to zero, it raises a one-cycle overflow pulse.

Top module: `tmr_srcctl_top`

## Requirements
- R1: After synchronous reset, the counter reads 0x00, the control register reads 0x00 while the comparator input is low, overflow is low, the shared analog pins report normal I/O, and the external count pin reports normal I/O.
- R2: While control bit 2 (run) is 0, the counter keeps its value whatever happens on the tick and the external pin.
- R3: With run=1 and control bit 1 (source) = 0, the counter adds one at each clock edge where `cyc_tick` is high, and `tpin_gpio_o` is 1. When source = 1, `tpin_gpio_o` is 0.
- R4: With run=1, source=1 and control bit 0 (edge) = 0, each low-to-high transition of `tpin_i` adds exactly one to the count, three clock edges after the transition is sampled. High-to-low transitions do not count.
- R5: With run=1, source=1 and edge=1, each high-to-low transition of `tpin_i` adds exactly one. Low-to-high transitions do not count.
- R6: Control bit 5 returns `cmp_i` after a two-flop synchroniser. Writes to bit 5 have no effect.
- R7: Control bits 4:0 read back what was written. Bits 7:6 always read 0.
- R8: Mode bits 4:3 decode as follows. 00: all shared pins are normal I/O. 01: the comparator is on and its output pin stays normal I/O. 10: the comparator is on and drives its output pin. 11: the op-amp is on and drives the output pin. The comparator and the op-amp are never on together.
- R9: An increment from 0xFF gives 0x00 and holds `ovf_o` high for exactly one cycle.
- R10: A bus write to the counter (`bus_sel`=1) loads `bus_wdata` and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select: 0 = control, 1 = counter |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| cyc_tick | input | 1 | Instruction-cycle tick |
| tpin_i | input | 1 | External count pin (asynchronous) |
| cmp_i | input | 1 | Comparator result (asynchronous) |
| tpin_gpio_o | output | 1 | External count pin is free for I/O |
| ana_gpio_o | output | 1 | Shared analog pins are all normal I/O |
| cmp_en_o | output | 1 | Comparator enabled |
| opa_en_o | output | 1 | Op-amp enabled |
| apin_drv_o | output | 1 | Analog output pin is driven by the analog block |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
A corrupted run, source or edge bit would show in the counter value that bus reads return. The error appears within one clock for tick counting and within three clocks of a pin transition for external counting. A broken edge detector shows up as a missing increment or a doubled one after a transition. A fault in the mode decode or in the read mux shows at once on the pin-function outputs or on `bus_rdata`. A fault in the comparator path shows two clocks after `cmp_i` changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W     = 8;
    localparam int REG_W     = 8;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        AM_GPIO    = 2'b00,
        AM_CMP     = 2'b01,
        AM_CMP_PIN = 2'b10,
        AM_OPAMP   = 2'b11
    } ana_mode_e;

    // Field order matches control bits 4..0
    typedef struct packed {
        ana_mode_e mode;
        logic      run;
        logic      src_ext;
        logic      fall_sel;
    } ctrl_t;

    typedef struct packed {
        logic gpio;
        logic cmp_en;
        logic opa_en;
        logic pin_drv;
    } pinmap_t;

    function automatic pinmap_t decode_mode(input ana_mode_e m);
        pinmap_t p;
        p.gpio    = (m == AM_GPIO);
        p.cmp_en  = (m == AM_CMP) || (m == AM_CMP_PIN);
        p.opa_en  = (m == AM_OPAMP);
        p.pin_drv = (m == AM_CMP_PIN) || (m == AM_OPAMP);
        return p;
    endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output pinmap_t          pins
);
    localparam int CW = $bits(ctrl_t);

    always_ff @(posedge clk) begin
        if (rst)     ctrl <= '0;
        else if (we) ctrl <= ctrl_t'(wdata[CW-1:0]);
    end

    assign pins = decode_mode(ctrl.mode);

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pins.cmp_en && pins.opa_en)) else $error("cmp and opamp both on"); // R8
    AST_RESET_CTRL: assert property (@(posedge clk)
        $past(rst) |-> (ctrl == '0)) else $error("ctrl not cleared"); // R1
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         src_ext,
    input  logic         fall_sel,
    input  logic         tick,
    input  logic         pin_s,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic pin_q;
    logic rise, fall, ext_hit, step;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_s;
    end

    assign rise    = pin_s & ~pin_q;
    assign fall    = ~pin_s & pin_q;
    assign ext_hit = fall_sel ? fall : rise;
    assign step    = run & (src_ext ? ext_hit : tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (ld) begin
            cnt <= ld_val;
            ovf <= 1'b0;
        end else begin
            ovf <= step && (cnt == {W{1'b1}});
            if (step) cnt <= cnt + 1'b1;
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld) |=> $stable(cnt)) else $error("count moved while off"); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val))) else $error("load lost"); // R10
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == '0)) else $error("ovf without wrap"); // R9
    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf) else $error("ovf longer than a cycle"); // R9
endmodule

// File: rtl/tmr_srcctl_top.sv
module tmr_srcctl_top
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             cyc_tick,
    input  logic             tpin_i,
    input  logic             cmp_i,
    output logic             tpin_gpio_o,
    output logic             ana_gpio_o,
    output logic             cmp_en_o,
    output logic             opa_en_o,
    output logic             apin_drv_o,
    output logic             ovf_o
);
    localparam int CW = $bits(ctrl_t);

    ctrl_t              ctrl;
    pinmap_t            pins;
    logic               pin_s, cmp_s;
    logic [CNT_W-1:0]   cnt;
    logic [REG_W-1:0]   ctrl_rd;

    tmr_sync #(.STAGES(SYNC_DEPTH)) u_pin_sync (.clk(clk), .rst(rst), .d(tpin_i), .q(pin_s));
    tmr_sync #(.STAGES(SYNC_DEPTH)) u_cmp_sync (.clk(clk), .rst(rst), .d(cmp_i),  .q(cmp_s));

    tmr_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(bus_we && !bus_sel), .wdata(bus_wdata),
        .ctrl(ctrl), .pins(pins)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .src_ext(ctrl.src_ext),
        .fall_sel(ctrl.fall_sel), .tick(cyc_tick), .pin_s(pin_s),
        .ld(bus_we && bus_sel), .ld_val(bus_wdata[CNT_W-1:0]),
        .cnt(cnt), .ovf(ovf_o)
    );

    always_comb begin
        ctrl_rd         = '0;
        ctrl_rd[CW-1:0] = ctrl;
        ctrl_rd[CW]     = cmp_s;
    end

    assign bus_rdata   = bus_sel ? REG_W'(cnt) : ctrl_rd;
    assign tpin_gpio_o = ~ctrl.src_ext;
    assign ana_gpio_o  = pins.gpio;
    assign cmp_en_o    = pins.cmp_en;
    assign opa_en_o    = pins.opa_en;
    assign apin_drv_o  = pins.pin_drv;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata[REG_W-1:CW+1] == '0)) else $error("unused bits set"); // R7
    AST_GPIO_EXCL: assert property (@(posedge clk) disable iff (rst)
        ana_gpio_o |-> !(cmp_en_o || opa_en_o || apin_drv_o)) else $error("gpio with analog"); // R8
endmodule

// File: tb/tmr_srcctl_top_tb.sv
module tmr_srcctl_top_tb;
    logic       clk = 0;
    logic       rst = 1;
    logic       bus_sel = 0, bus_we = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       cyc_tick = 0, tpin_i = 0, cmp_i = 0;
    logic       tpin_gpio_o, ana_gpio_o, cmp_en_o, opa_en_o, apin_drv_o, ovf_o;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    tmr_srcctl_top u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_sel = sel; bus_we = 1; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        bus_sel = sel; #1; d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cyc_tick = 1;
            @(negedge clk); cyc_tick = 0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1, v); chk("R1 count", v, 8'h00);
        rd(0, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 ana gpio", ana_gpio_o, 1);
        chk("R1 tpin gpio", tpin_gpio_o, 1);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        wr(0, 8'h00); wr(1, 8'h33);
        ticks(5);
        tpin_i = 1; repeat (5) @(negedge clk); tpin_i = 0; repeat (5) @(negedge clk);
        rd(1, v); chk("R2 hold", v, 8'h33);
    endtask

    task automatic t_internal;
        logic [7:0] v;
        wr(1, 8'h10); wr(0, 8'h04);
        chk("R3 tpin gpio", tpin_gpio_o, 1);
        ticks(7);
        rd(1, v); chk("R3 tick count", v, 8'h17);
    endtask

    task automatic t_ext_rise;
        logic [7:0] v;
        wr(1, 8'h00); wr(0, 8'h06);
        chk("R3 tpin gpio off", tpin_gpio_o, 0);
        ticks(3);
        rd(1, v); chk("R4 ticks ignored", v, 8'h00);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tpin_i = 1; repeat (5) @(negedge clk);
            tpin_i = 0; repeat (5) @(negedge clk);
        end
        rd(1, v); chk("R4 rising count", v, 8'h03);
        @(negedge clk); tpin_i = 1;
        @(negedge clk); @(negedge clk);
        rd(1, v); chk("R4 before latency", v, 8'h03);
        @(negedge clk);
        rd(1, v); chk("R4 at latency", v, 8'h04);
        repeat (4) @(negedge clk); tpin_i = 0; repeat (5) @(negedge clk);
    endtask

    task automatic t_ext_fall;
        logic [7:0] v;
        wr(1, 8'h00); wr(0, 8'h07);
        @(negedge clk); tpin_i = 1; repeat (5) @(negedge clk);
        rd(1, v); chk("R5 rise ignored", v, 8'h00);
        tpin_i = 0; repeat (5) @(negedge clk);
        rd(1, v); chk("R5 falling count", v, 8'h01);
    endtask

    task automatic t_regbits;
        logic [7:0] v;
        cmp_i = 1; repeat (3) @(negedge clk);
        wr(0, 8'hC0);
        rd(0, v); chk("R6 cmp high", v, 8'h20);
        wr(0, 8'hFF);
        rd(0, v); chk("R7 readback", v, 8'h3F);
        cmp_i = 0; @(negedge clk);
        rd(0, v); chk("R6 sync delay", v, 8'h3F);
        @(negedge clk);
        rd(0, v); chk("R6 cmp low", v, 8'h1F);
        wr(0, 8'h2A);
        rd(0, v); chk("R6 write ignored", v, 8'h0A);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            wr(0, 8'(m << 3));
            chk("R8 gpio", ana_gpio_o, int'(m == 0));
            chk("R8 cmp", cmp_en_o, int'(m == 1 || m == 2));
            chk("R8 opa", opa_en_o, int'(m == 3));
            chk("R8 pin", apin_drv_o, int'(m >= 2));
        end
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        wr(1, 8'hFE); wr(0, 8'h04);
        ticks(1);
        rd(1, v); chk("R9 ff", v, 8'hFF);
        chk("R9 no ovf", ovf_o, 0);
        @(negedge clk); cyc_tick = 1;
        @(negedge clk); cyc_tick = 0;
        rd(1, v); chk("R9 wrap", v, 8'h00);
        chk("R9 ovf pulse", ovf_o, 1);
        @(negedge clk);
        chk("R9 ovf drop", ovf_o, 0);
    endtask

    task automatic t_load;
        logic [7:0] v;
        wr(0, 8'h04); wr(1, 8'h20);
        @(negedge clk); cyc_tick = 1; bus_sel = 1; bus_we = 1; bus_wdata = 8'h50;
        @(negedge clk); cyc_tick = 0; bus_we = 0;
        rd(1, v); chk("R10 load priority", v, 8'h50);
        ticks(1);
        rd(1, v); chk("R10 after load", v, 8'h51);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset; t_hold; t_internal; t_ext_rise; t_ext_fall;
        t_regbits; t_modes; t_wrap; t_load;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule